// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is one input port of a five-port packet router in a 2D mesh. The upstream router offers one 32-bit flit per cycle. Each flit comes with a request strobe and a 2-bit channel number. The port stores the flit in one of four virtual-channel FIFOs, each four flits deep. It acknowledges the flit in the same cycle, unless the addressed FIFO is full.

A transmission controller works on the stored packets one packet at a time. When it is idle, it searches the channels in round-robin order for one that holds a waiting packet. It sends the head flit's destination to an external routing unit and records the returned direction for that channel. From the next cycle it requests the output arbiter. While the arbiter's enable is high, it streams the packet's flits toward the crossbar, tagged with their channel number. The request drops once the tail flit has left.

Bits [31:30] of a flit hold its type: 0 head, 1 body, 2 tail, 3 single. Bits [27:24] of a head or single flit hold the destination identifier.

Top module: `vc_input_port`

## Requirements
- R1: When `up_req` is high and the channel selected by `up_vc` is not full, `up_ack` is high in that same cycle and the flit is appended to that channel's FIFO.
- R2: When the addressed channel is full, `up_ack` stays low and the flit is discarded. The channel's contents and the data later read from it are unaffected.
- R3: Bit i of `vc_full` or `vc_empty` reports channel i. A channel reports full when it holds 4 flits and empty when it holds 0. Both flags reflect the count at the start of the cycle.
- R4: A channel that is read and written in the same cycle keeps its flit order, and its flit count is unchanged.
- R5: `rt_req` is high only while the controller is idle and some channel is non-empty. `rt_dest` then carries bits [27:24] of the front flit of the selected channel, which is always a head (type 0) or single (type 3) flit.
- R6: The direction on `rt_dir` in the routing cycle is stored for that channel. It is presented on `out_dir` unchanged for as long as `arb_req` stays high.
- R7: `arb_req` rises in the cycle after the routing request. It stays high until the cycle in which the tail (type 2) or single flit is read, and it is low in the following cycle.
- R8: A flit is read only in a cycle with `arb_req` high, `arb_en` high and the active channel non-empty. In that cycle `xb_valid` is high, `xb_data` is the channel's front flit and `xb_vc` is the channel number.
- R9: When idle, the controller selects the first non-empty channel counting upward, with wrap-around, from the channel after the one served last. After reset the search starts at channel 0.
- R10: After reset, every channel is empty and `rt_req`, `arb_req` and `xb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream write request |
| up_vc | input | 2 | Target virtual channel of the offered flit |
| up_data | input | 32 | Offered flit |
| up_ack | output | 1 | Flit accepted this cycle |
| vc_full | output | 4 | Per-channel full flags |
| vc_empty | output | 4 | Per-channel empty flags |
| rt_req | output | 1 | Routing request for a head or single flit |
| rt_dest | output | 4 | Destination identifier sent to the routing unit |
| rt_dir | input | 2 | Direction returned by the routing unit, same cycle |
| arb_req | output | 1 | Request to the output arbiter |
| out_dir | output | 2 | Output direction of the packet being sent |
| arb_en | input | 1 | Arbiter enable for this port |
| xb_valid | output | 1 | Flit on `xb_data` is read this cycle |
| xb_data | output | 32 | Flit toward the crossbar |
| xb_vc | output | 2 | Virtual channel of the flit on `xb_data` |

## Verification
Assertions check the following on every cycle:
- no FIFO is written while full or read while empty;
- a doubly accessed channel remains non-empty;
- the routing request and the arbiter request never overlap;
- the request is held until a flit is read;
- the direction is stable while the request is held;
- crossbar traffic appears only under the arbiter's enable.

Some behaviours only the bench's scenarios can show. These are flit ordering across interleaved channels, the round-robin choice of the next packet, the discarding of writes to a full channel, and the release of the request after the tail flit. The bench's reference model of queues shows them by comparing every output on every cycle under random traffic, a forced-full phase and a drain phase.

// File: rtl/vcip_pkg.sv
package vcip_pkg;
    localparam int FLIT_W   = 32;
    localparam int NUM_VC   = 4;
    localparam int VC_DEPTH = 4;
    localparam int DEST_W   = 4;
    localparam int DEST_LSB = 24;
    localparam int DIR_W    = 2;

    typedef enum logic [1:0] {
        FT_HEAD   = 2'd0,
        FT_BODY   = 2'd1,
        FT_TAIL   = 2'd2,
        FT_SINGLE = 2'd3
    } flit_kind_e;
endpackage

// File: rtl/vcip_fifo.sv
module vcip_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wptr;
        logic [PW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.wptr] = wr_data;
            st_d.wptr           = bump(st_q.wptr);
        end
        if (rd_en) begin
            st_d.rptr = bump(st_q.rptr);
        end
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[st_q.rptr];
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && full)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && empty)); // R8
    AST_BOTH_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> !empty); // R4
endmodule

// File: rtl/vcip_link_ctrl.sv
module vcip_link_ctrl #(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [VC_W-1:0]   up_vc,
    input  logic [NUM_VC-1:0] full,
    output logic              up_ack,
    output logic [NUM_VC-1:0] wr_en
);
    always_comb begin
        wr_en = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (up_req && (up_vc == VC_W'(v)) && !full[v]) begin
                wr_en[v] = 1'b1;
            end
        end
    end

    assign up_ack = |wr_en;

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |-> up_req); // R1
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R1
endmodule

// File: rtl/vcip_xmit_ctrl.sv
module vcip_xmit_ctrl #(
    parameter int W        = 32,
    parameter int NUM_VC   = 4,
    parameter int VC_W     = 2,
    parameter int DEST_W   = 4,
    parameter int DEST_LSB = 24,
    parameter int DIR_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_VC-1:0]          empty,
    input  logic [NUM_VC-1:0][W-1:0]   front,
    output logic                       rt_req,
    output logic [DEST_W-1:0]          rt_dest,
    input  logic [DIR_W-1:0]           rt_dir,
    output logic                       arb_req,
    output logic [DIR_W-1:0]           out_dir,
    input  logic                       arb_en,
    output logic [NUM_VC-1:0]          rd_en,
    output logic                       xb_valid,
    output logic [W-1:0]               xb_data,
    output logic [VC_W-1:0]            xb_vc
);
    import vcip_pkg::*;

    typedef struct packed {
        logic                          busy;
        logic [VC_W-1:0]               cur;
        logic [VC_W-1:0]               last;
        logic [NUM_VC-1:0][DIR_W-1:0]  dir;
    } xc_st_t;

    xc_st_t st_d, st_q;

    logic            found;
    logic [VC_W-1:0] sel;
    flit_kind_e      out_kind;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 1; k <= NUM_VC; k++) begin
            if (!found && !empty[(int'(st_q.last) + k) % NUM_VC]) begin
                found = 1'b1;
                sel   = VC_W'((int'(st_q.last) + k) % NUM_VC);
            end
        end
    end

    assign rt_req   = !st_q.busy && found;
    assign rt_dest  = front[sel][DEST_LSB +: DEST_W];
    assign arb_req  = st_q.busy;
    assign out_dir  = st_q.dir[st_q.cur];
    assign xb_valid = st_q.busy && arb_en && !empty[st_q.cur];
    assign xb_data  = front[st_q.cur];
    assign xb_vc    = st_q.cur;
    assign out_kind = flit_kind_e'(front[st_q.cur][W-1 -: 2]);

    always_comb begin
        rd_en = '0;
        if (xb_valid) begin
            rd_en[st_q.cur] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (found) begin
                st_d.busy     = 1'b1;
                st_d.cur      = sel;
                st_d.last     = sel;
                st_d.dir[sel] = rt_dir;
            end
        end else if (xb_valid && (out_kind == FT_TAIL || out_kind == FT_SINGLE)) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= VC_W'(NUM_VC - 1);
        end else begin
            st_q <= st_d;
        end
    end

    AST_ROUTE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rt_req |-> !arb_req); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !xb_valid) |=> arb_req); // R7
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && $past(arb_req)) |-> $stable(out_dir)); // R6
    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid |-> (arb_en && arb_req)); // R8
endmodule

// File: rtl/vc_input_port.sv
module vc_input_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up_req,
    input  logic [1:0]  up_vc,
    input  logic [31:0] up_data,
    output logic        up_ack,
    output logic [3:0]  vc_full,
    output logic [3:0]  vc_empty,
    output logic        rt_req,
    output logic [3:0]  rt_dest,
    input  logic [1:0]  rt_dir,
    output logic        arb_req,
    output logic [1:0]  out_dir,
    input  logic        arb_en,
    output logic        xb_valid,
    output logic [31:0] xb_data,
    output logic [1:0]  xb_vc
);
    import vcip_pkg::*;

    localparam int VC_W = $clog2(NUM_VC);

    logic [NUM_VC-1:0]             wr_en;
    logic [NUM_VC-1:0]             rd_en;
    logic [NUM_VC-1:0][FLIT_W-1:0] front;

    vcip_link_ctrl #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_req (up_req),
        .up_vc  (up_vc),
        .full   (vc_full),
        .up_ack (up_ack),
        .wr_en  (wr_en)
    );

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        vcip_fifo #(.W(FLIT_W), .DEPTH(VC_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[v]),
            .wr_data (up_data),
            .rd_en   (rd_en[v]),
            .rd_data (front[v]),
            .full    (vc_full[v]),
            .empty   (vc_empty[v])
        );
    end

    vcip_xmit_ctrl #(
        .W(FLIT_W), .NUM_VC(NUM_VC), .VC_W(VC_W),
        .DEST_W(DEST_W), .DEST_LSB(DEST_LSB), .DIR_W(DIR_W)
    ) u_xmit (
        .clk      (clk),
        .rst_n    (rst_n),
        .empty    (vc_empty),
        .front    (front),
        .rt_req   (rt_req),
        .rt_dest  (rt_dest),
        .rt_dir   (rt_dir),
        .arb_req  (arb_req),
        .out_dir  (out_dir),
        .arb_en   (arb_en),
        .rd_en    (rd_en),
        .xb_valid (xb_valid),
        .xb_data  (xb_data),
        .xb_vc    (xb_vc)
    );
endmodule

// File: tb/vc_input_port_test.sv
module vc_input_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0;
    logic [1:0]  up_vc = '0;
    logic [31:0] up_data = '0;
    logic        up_ack;
    logic [3:0]  vc_full, vc_empty;
    logic        rt_req;
    logic [3:0]  rt_dest;
    logic [1:0]  rt_dir;
    logic        arb_req;
    logic [1:0]  out_dir;
    logic        arb_en = 1'b0;
    logic        xb_valid;
    logic [31:0] xb_data;
    logic [1:0]  xb_vc;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // external routing unit: any fixed function of the destination
    assign rt_dir = rt_dest[1:0] ^ rt_dest[3:2];

    vc_input_port uut (.*);

    // reference model state
    logic [31:0] mq [4][$];
    bit          m_busy = 0;
    int          m_cur = 0;
    int          m_last = 3;
    logic [1:0]  m_dir [4];
    bit          in_pkt [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic make_flit(input int v, output logic [31:0] f);
        logic [1:0] kind;
        if (!in_pkt[v]) kind = ($urandom % 2) ? 2'd3 : 2'd0;
        else            kind = ($urandom % 3 == 0) ? 2'd2 : 2'd1;
        f = $urandom;
        f[31:30] = kind;
    endtask

    // compare all outputs, then advance the model to the next edge
    task automatic step_model();
        bit         e_ack, found, e_valid;
        int         sel;
        logic [3:0] e_full, e_empty;
        logic [31:0] f;
        #1;
        e_ack = up_req && (mq[up_vc].size() < 4);
        for (int v = 0; v < 4; v++) begin
            e_full[v]  = (mq[v].size() == 4);
            e_empty[v] = (mq[v].size() == 0);
        end
        chk("R1/R2 up_ack", 32'(up_ack), 32'(e_ack));
        chk("R3 vc_full", 32'(vc_full), 32'(e_full));
        chk("R3 vc_empty", 32'(vc_empty), 32'(e_empty));
        found = 0; sel = 0;
        for (int k = 1; k <= 4; k++) begin
            if (!found && mq[(m_last + k) % 4].size() != 0) begin
                found = 1; sel = (m_last + k) % 4;
            end
        end
        chk("R5 rt_req", 32'(rt_req), 32'(!m_busy && found));
        if (!m_busy && found) begin
            chk("R9 selected head dest", 32'(rt_dest), 32'(mq[sel][0][27:24]));
            chk("R5 head type", 32'(mq[sel][0][31:30] == 2'd0 || mq[sel][0][31:30] == 2'd3), 32'd1);
        end
        chk("R7 arb_req", 32'(arb_req), 32'(m_busy));
        if (m_busy) chk("R6 out_dir", 32'(out_dir), 32'(m_dir[m_cur]));
        e_valid = m_busy && arb_en && (mq[m_cur].size() != 0);
        chk("R8 xb_valid", 32'(xb_valid), 32'(e_valid));
        if (e_valid) begin
            chk("R8/R4 xb_data", xb_data, mq[m_cur][0]);
            chk("R8 xb_vc", 32'(xb_vc), 32'(m_cur));
        end
        // next state
        if (e_valid) begin
            f = mq[m_cur].pop_front();
            if (f[31:30] == 2'd2 || f[31:30] == 2'd3) m_busy = 0;
        end else if (!m_busy && found) begin
            m_busy = 1; m_cur = sel; m_last = sel;
            m_dir[sel] = rt_dir;
        end
        if (e_ack) begin
            mq[up_vc].push_back(up_data);
            if (up_data[31:30] == 2'd0) in_pkt[up_vc] = 1;
            if (up_data[31:30] == 2'd2) in_pkt[up_vc] = 0;
        end
    endtask

    task automatic drive(input bit req, input int v, input bit en);
        logic [31:0] f;
        make_flit(v, f);
        up_req  = req;
        up_vc   = 2'(v);
        up_data = f;
        arb_en  = en;
    endtask

    initial begin
        for (int v = 0; v < 4; v++) begin in_pkt[v] = 0; m_dir[v] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        #1;
        chk("R10 empty after reset", 32'(vc_empty), 32'hF);
        chk("R10 no requests", 32'({rt_req, arb_req, xb_valid}), 32'd0);
        // R2/R3: fill channel 2 with the arbiter disabled, keep offering
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            drive(1'b1, 2, 1'b0);
            step_model();
        end
        // R4/R7/R9: random mixed traffic
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            drive(($urandom % 10) < 7, $urandom % 4, ($urandom % 10) < 6);
            step_model();
        end
        // R4: heavy traffic on a single channel with the arbiter always on
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            drive(1'b1, 1, 1'b1);
            step_model();
        end
        // drain
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            drive(1'b0, 0, 1'b1);
            step_model();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule